// File: doc/BRIEF.md
# Pulse-Width Serial Bus Frame Receiver

This block recovers frames from a single-wire serial bus whose bits are coded by the ratio of high time to low time. A long high pulse opens a frame. Each later bit is classified when its high phase ends. A short high phase is a 1 and a long high phase is a 0. Bytes arrive most significant bit first, and each byte is followed by an odd-parity bit.

A frame holds three address bytes, a 4-bit field sent without parity, a length byte, that many payload bytes and a closing checksum byte. From the third byte on, the receiver acknowledges every correctly received byte by driving the line high for a fixed time after the sender has pulled it low. The acknowledge output is combined with the sender's drive as a wired-OR. At the end of a frame the host sees a one-cycle valid pulse together with the address, field, length and payload. Parity faults, oversize lengths and stalled lines each end reception with their own one-cycle flag. After any of these the receiver waits for a new start pulse.

All times are counted in clock cycles and set by parameters.

Top module: `pwrx_frame_rx`

## Requirements
- R1: After reset, ack_drive and all five status outputs are 0.
- R2: A high phase of at least START_MIN cycles, followed by a falling edge, starts a new frame. It does so from any state, and it discards a frame that is only partly received.
- R3: A bit whose high phase is shorter than BIT_SPLIT cycles decodes as 1; a longer one decodes as 0. The first bit of a byte is its bit 7.
- R4: The parity bit must make the number of ones among the 8 data bits and the parity bit odd. If it does not, parity_error pulses for one cycle and no acknowledge is driven for that byte. Nothing more is reported until the next start pulse.
- R5: The third address byte, the length byte, each payload byte and the checksum byte are each acknowledged when their parity is correct. The acknowledge is ack_drive held high for exactly ACK_CYC cycles after the parity bit's high phase. The first two address bytes and the 4-bit field are never acknowledged.
- R6: After the checksum byte, frame_valid pulses for one cycle. With it, frame_addr holds the three address bytes with the first received in bits 23:16, and frame_field holds the four field bits with the first received in bit 3. frame_size holds the length byte, and payload byte i sits in frame_data bits 8i+7:8i.
- R7: checksum_error is 1 together with frame_valid exactly when the checksum byte differs from the 8-bit sum of 0x0F, the length byte and all payload bytes.
- R8: A length byte greater than MAX_LEN is not acknowledged. Instead length_error pulses for one cycle and reception stops until the next start pulse.
- R9: If the line stays low for TIMEOUT cycles while bits are expected, timeout_error pulses for one cycle and reception stops.
- R10: Each of the five status outputs is a single-cycle pulse, and frame_valid, parity_error, timeout_error and length_error are never high in the same cycle.
- R11: A length byte of 0 is acknowledged and is followed directly by the checksum byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_line | input | 1 | Sensed bus level (sender drive OR ack_drive) |
| ack_drive | output | 1 | Receiver drives the line high for an acknowledge |
| frame_valid | output | 1 | One-cycle pulse when a complete frame is received |
| checksum_error | output | 1 | Checksum mismatch, valid with frame_valid |
| parity_error | output | 1 | One-cycle pulse on a parity fault |
| timeout_error | output | 1 | One-cycle pulse on a stalled low line |
| length_error | output | 1 | One-cycle pulse on a length above MAX_LEN |
| frame_addr | output | 24 | Three address bytes, first received in bits 23:16 |
| frame_field | output | 4 | The 4-bit field, first received bit in bit 3 |
| frame_size | output | 8 | Length byte of the frame |
| frame_data | output | MAX_LEN*8 | Payload, byte i in bits 8i+7:8i |

## Verification
A bit counter or parity accumulator that slips by one cannot stay hidden. It either turns a good byte into a parity_error pulse, or it moves the acknowledge onto a byte where the sender expects none. Both show up within one byte time. A wrong phase or length counter shows up as a status pulse of the wrong kind, or one at the wrong moment, or as a valid frame with shifted payload bytes, when the checksum byte closes the frame. An acknowledge counter that is off shows as an ack_drive pulse of the wrong width within that single slot.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_BYTE,
      S_NIB,
      S_ACK,
      S_DRAIN
   } rx_state_t;

   typedef enum logic [1:0] {
      P_ADDR,
      P_SIZE,
      P_DATA,
      P_SUM
   } rx_phase_t;

   localparam logic [7:0] SUM_SEED = 8'h0F;

endpackage

// File: rtl/pwrx_pulse_meter.sv
module pwrx_pulse_meter #(
   parameter int SYNC_STAGES = 2,
   parameter int START_MIN   = 100,
   parameter int BIT_SPLIT   = 26,
   parameter int TIMEOUT     = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic sym_evt,
   output logic sym_one,
   output logic start_evt,
   output logic timeout_evt
);
   localparam int MAXV  = (START_MIN > TIMEOUT) ? START_MIN : TIMEOUT;
   localparam int CNT_W = $clog2(MAXV + 2);
   localparam logic [CNT_W-1:0] START_C = CNT_W'(START_MIN);
   localparam logic [CNT_W-1:0] SPLIT_C = CNT_W'(BIT_SPLIT);
   localparam logic [CNT_W-1:0] TOUT_C  = CNT_W'(TIMEOUT);

   logic             line_s;
   logic             line_d;
   logic [CNT_W-1:0] hi_cnt;
   logic [CNT_W-1:0] lo_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_s = line_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
         end
         assign line_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b0;
         hi_cnt <= '0;
         lo_cnt <= '0;
      end else begin
         line_d <= line_s;
         if (line_s) begin
            lo_cnt <= '0;
            if (!line_d)          hi_cnt <= CNT_W'(1);
            else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
         end else if (lo_cnt != '1) begin
            lo_cnt <= lo_cnt + 1'b1;
         end
      end
   end

   logic fall;
   assign fall        = line_d && !line_s;
   assign start_evt   = fall && (hi_cnt >= START_C);
   assign sym_evt     = fall && (hi_cnt < START_C);
   assign sym_one     = hi_cnt < SPLIT_C;
   assign timeout_evt = !line_s && (lo_cnt == TOUT_C);

endmodule

// File: rtl/pwrx_payload_buf.sv
module pwrx_payload_buf #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [7:0]         wr_byte,
   output logic [DEPTH*8-1:0] rd_flat
);
   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
         logic [7:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 slot_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(gi)))   slot_q <= wr_byte;
         end
         assign rd_flat[gi*8 +: 8] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/pwrx_frame_assembler.sv
module pwrx_frame_assembler
   import pwrx_pkg::*;
#(
   parameter int MAX_LEN = 16,
   parameter int ACK_CYC = 20,
   parameter int IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sym_evt,
   input  logic             sym_one,
   input  logic             start_evt,
   input  logic             timeout_evt,
   output logic             ack_drive,
   output logic             frame_valid,
   output logic             checksum_error,
   output logic             parity_error,
   output logic             timeout_error,
   output logic             length_error,
   output logic [23:0]      frame_addr,
   output logic [3:0]       frame_field,
   output logic [7:0]       frame_size,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_byte
);
   localparam int ACK_W = $clog2(ACK_CYC + 1);
   localparam logic [7:0]       SIZE_LIM = 8'(MAX_LEN);
   localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_CYC - 1);

   rx_state_t        st_q, ret_q;
   rx_phase_t        ph_q;
   logic [3:0]       bit_q;
   logic [7:0]       sh_q;
   logic             par_q;
   logic [1:0]       acnt_q;
   logic [IDX_W-1:0] dcnt_q;
   logic [7:0]       sum_q;
   logic [ACK_W-1:0] ack_q;

   logic par_ok;
   assign par_ok = par_q ^ sym_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE;  ret_q <= S_IDLE;  ph_q <= P_ADDR;
         bit_q <= '0;  sh_q <= '0;  par_q <= 1'b0;  acnt_q <= '0;
         dcnt_q <= '0; sum_q <= SUM_SEED;  ack_q <= '0;
         ack_drive <= 1'b0;  frame_valid <= 1'b0;  checksum_error <= 1'b0;
         parity_error <= 1'b0;  timeout_error <= 1'b0;  length_error <= 1'b0;
         frame_addr <= '0;  frame_field <= '0;  frame_size <= '0;
         wr_en <= 1'b0;  wr_idx <= '0;  wr_byte <= '0;
      end else begin
         frame_valid    <= 1'b0;
         checksum_error <= 1'b0;
         parity_error   <= 1'b0;
         timeout_error  <= 1'b0;
         length_error   <= 1'b0;
         wr_en          <= 1'b0;
         if (start_evt) begin
            st_q <= S_BYTE;  ph_q <= P_ADDR;  acnt_q <= '0;
            bit_q <= '0;  par_q <= 1'b0;  dcnt_q <= '0;
            sum_q <= SUM_SEED;  ack_drive <= 1'b0;
         end else if (timeout_evt && (st_q == S_BYTE || st_q == S_NIB)) begin
            timeout_error <= 1'b1;
            st_q          <= S_IDLE;
         end else begin
            case (st_q)
               S_NIB: if (sym_evt) begin
                  frame_field <= {frame_field[2:0], sym_one};
                  if (bit_q == 4'd3) begin
                     st_q <= S_BYTE;  ph_q <= P_SIZE;  bit_q <= '0;  par_q <= 1'b0;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
               S_BYTE: if (sym_evt) begin
                  if (bit_q != 4'd8) begin
                     sh_q  <= {sh_q[6:0], sym_one};
                     par_q <= par_q ^ sym_one;
                     bit_q <= bit_q + 1'b1;
                  end else begin
                     bit_q <= '0;
                     par_q <= 1'b0;
                     if (!par_ok) begin
                        parity_error <= 1'b1;
                        st_q         <= S_IDLE;
                     end else begin
                        case (ph_q)
                           P_ADDR: begin
                              frame_addr <= {frame_addr[15:0], sh_q};
                              if (acnt_q == 2'd2) begin
                                 ret_q <= S_NIB;  st_q <= S_ACK;
                                 ack_drive <= 1'b1;  ack_q <= '0;
                              end else begin
                                 acnt_q <= acnt_q + 1'b1;
                              end
                           end
                           P_SIZE: begin
                              if (sh_q > SIZE_LIM) begin
                                 length_error <= 1'b1;
                                 st_q         <= S_IDLE;
                              end else begin
                                 frame_size <= sh_q;
                                 sum_q      <= sum_q + sh_q;
                                 ph_q       <= (sh_q == 8'd0) ? P_SUM : P_DATA;
                                 ret_q <= S_BYTE;  st_q <= S_ACK;
                                 ack_drive <= 1'b1;  ack_q <= '0;
                              end
                           end
                           P_DATA: begin
                              wr_en   <= 1'b1;
                              wr_idx  <= dcnt_q;
                              wr_byte <= sh_q;
                              sum_q   <= sum_q + sh_q;
                              dcnt_q  <= dcnt_q + 1'b1;
                              if ((8'(dcnt_q) + 8'd1) == frame_size) ph_q <= P_SUM;
                              ret_q <= S_BYTE;  st_q <= S_ACK;
                              ack_drive <= 1'b1;  ack_q <= '0;
                           end
                           default: begin
                              frame_valid    <= 1'b1;
                              checksum_error <= (sh_q != sum_q);
                              ret_q <= S_IDLE;  st_q <= S_ACK;
                              ack_drive <= 1'b1;  ack_q <= '0;
                           end
                        endcase
                     end
                  end
               end
               S_ACK: begin
                  if (ack_q == ACK_LAST) begin
                     ack_drive <= 1'b0;
                     st_q      <= S_DRAIN;
                  end else begin
                     ack_q <= ack_q + 1'b1;
                  end
               end
               S_DRAIN: if (sym_evt) st_q <= ret_q;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwrx_frame_rx.sv
module pwrx_frame_rx #(
   parameter int MAX_LEN     = 16,
   parameter int SYNC_STAGES = 2,
   parameter int START_MIN   = 100,
   parameter int BIT_SPLIT   = 26,
   parameter int TIMEOUT     = 64,
   parameter int ACK_CYC     = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_line,
   output logic                 ack_drive,
   output logic                 frame_valid,
   output logic                 checksum_error,
   output logic                 parity_error,
   output logic                 timeout_error,
   output logic                 length_error,
   output logic [23:0]          frame_addr,
   output logic [3:0]           frame_field,
   output logic [7:0]           frame_size,
   output logic [MAX_LEN*8-1:0] frame_data
);
   localparam int IDX_W = $clog2(MAX_LEN + 1);

   generate
      if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
         $error("pwrx_frame_rx: MAX_LEN must lie in 1..255");
      end
      if (BIT_SPLIT < 2 || BIT_SPLIT >= START_MIN) begin : g_bad_split
         $error("pwrx_frame_rx: BIT_SPLIT must lie below START_MIN");
      end
      if (ACK_CYC < 1 || ACK_CYC >= START_MIN) begin : g_bad_ack
         $error("pwrx_frame_rx: ACK_CYC must lie below START_MIN");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("pwrx_frame_rx: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic             sym_evt, sym_one, start_evt, timeout_evt;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       wr_byte;

   pwrx_pulse_meter #(
      .SYNC_STAGES(SYNC_STAGES), .START_MIN(START_MIN),
      .BIT_SPLIT(BIT_SPLIT),     .TIMEOUT(TIMEOUT)
   ) i_meter (
      .clk(clk), .rst_n(rst_n), .line_in(bus_line),
      .sym_evt(sym_evt), .sym_one(sym_one),
      .start_evt(start_evt), .timeout_evt(timeout_evt)
   );

   pwrx_frame_assembler #(
      .MAX_LEN(MAX_LEN), .ACK_CYC(ACK_CYC), .IDX_W(IDX_W)
   ) i_asm (
      .clk(clk), .rst_n(rst_n),
      .sym_evt(sym_evt), .sym_one(sym_one),
      .start_evt(start_evt), .timeout_evt(timeout_evt),
      .ack_drive(ack_drive), .frame_valid(frame_valid),
      .checksum_error(checksum_error), .parity_error(parity_error),
      .timeout_error(timeout_error), .length_error(length_error),
      .frame_addr(frame_addr), .frame_field(frame_field),
      .frame_size(frame_size),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte)
   );

   pwrx_payload_buf #(
      .DEPTH(MAX_LEN), .IDX_W(IDX_W)
   ) i_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
      .rd_flat(frame_data)
   );
endmodule

// File: rtl/pwrx_frame_rx_chk.sv
module pwrx_frame_rx_chk #(
   parameter int MAX_LEN = 16,
   parameter int ACK_CYC = 20
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ack_drive,
   input logic       frame_valid,
   input logic       checksum_error,
   input logic       parity_error,
   input logic       timeout_error,
   input logic       length_error,
   input logic [7:0] frame_size
);
   logic [15:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= '0;
      else if (ack_drive) run_q <= run_q + 1'b1;
      else                run_q <= '0;
   end

   AST_ACK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_drive) |-> (run_q == 16'(ACK_CYC)));  // R5
   AST_ERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (parity_error || length_error) |=> !ack_drive);  // R4
   AST_CSUM_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      checksum_error |-> frame_valid);  // R7
   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_valid, parity_error, timeout_error, length_error}));  // R10
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);  // R6
   AST_SIZE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> (frame_size <= 8'(MAX_LEN)));  // R8
   AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_error |-> !ack_drive);  // R9
endmodule

bind pwrx_frame_rx pwrx_frame_rx_chk #(
   .MAX_LEN(MAX_LEN), .ACK_CYC(ACK_CYC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ack_drive(ack_drive),
   .frame_valid(frame_valid), .checksum_error(checksum_error),
   .parity_error(parity_error), .timeout_error(timeout_error),
   .length_error(length_error), .frame_size(frame_size)
);

// File: tb/test_pwrx_frame_rx.sv
module test_pwrx_frame_rx;
   localparam int MAXL = 16;
   localparam int ACKC = 20;

   typedef struct packed {
      logic [2:0]   kind;   // 1 valid, 2 parity, 3 timeout, 4 length
      logic         cerr;
      logic [23:0]  addr;
      logic [3:0]   fld;
      logic [7:0]   size;
      logic [127:0] data;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx = 1'b0;
   logic bus_line;
   logic ack_drive, frame_valid, checksum_error, parity_error, timeout_error, length_error;
   logic [23:0] frame_addr;
   logic [3:0]  frame_field;
   logic [7:0]  frame_size;
   logic [MAXL*8-1:0] frame_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit mon_on  = 1'b0;
   bit ack_win = 1'b0;
   int ack_run = 0;
   ev_t exq[$];
   ev_t mon_e;

   always #2 clk = ~clk;
   assign bus_line = tx | ack_drive;

   pwrx_frame_rx i_pwrx_frame_rx (
      .clk(clk), .rst_n(rst_n), .bus_line(bus_line), .ack_drive(ack_drive),
      .frame_valid(frame_valid), .checksum_error(checksum_error),
      .parity_error(parity_error), .timeout_error(timeout_error),
      .length_error(length_error), .frame_addr(frame_addr),
      .frame_field(frame_field), .frame_size(frame_size), .frame_data(frame_data)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference model: every clock, compare status outputs to the expected event queue
   always @(negedge clk) begin
      if (mon_on) begin
         int nact;
         int k;
         nact = int'(frame_valid) + int'(parity_error) + int'(timeout_error) + int'(length_error);
         if (ack_drive) begin
            if (ack_win) ack_run++;
            else chk(1'b0, "R5", "ack outside an acknowledge slot", 1, 0);
         end
         if (checksum_error && !frame_valid) chk(1'b0, "R7", "checksum flag without valid", 1, 0);
         if (nact > 0) begin
            chk(nact == 1, "R10", "status pulses at once", nact, 1);
            k = frame_valid ? 1 : parity_error ? 2 : timeout_error ? 3 : 4;
            if (exq.size() == 0) begin
               chk(1'b0, "R6", "unexpected status kind", k, 0);
            end else begin
               mon_e = exq.pop_front();
               chk(k == int'(mon_e.kind), "R6", "status kind", k, mon_e.kind);
               if (mon_e.kind == 3'd1) begin
                  chk(checksum_error == mon_e.cerr, "R7", "checksum_error", checksum_error, mon_e.cerr);
                  chk(frame_addr == mon_e.addr, "R6", "address", frame_addr, mon_e.addr);
                  chk(frame_field == mon_e.fld, "R6", "field", frame_field, mon_e.fld);
                  chk(frame_size == mon_e.size, "R6", "size", frame_size, mon_e.size);
                  for (int i = 0; i < int'(mon_e.size); i++)
                     chk(frame_data[i*8 +: 8] == mon_e.data[i*8 +: 8], "R3", "payload byte",
                         frame_data[i*8 +: 8], mon_e.data[i*8 +: 8]);
               end
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic hold(input logic v, input int n);
      tx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic v);
      hold(1'b1, v ? 20 : 33);
      hold(1'b0, v ? 20 : 7);
   endtask

   task automatic send_start();
      hold(1'b1, 170);
      hold(1'b0, 20);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit badp, input bit ack_exp);
      logic p;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      p = ~^b;
      if (badp) p = ~p;
      hold(1'b1, p ? 20 : 33);
      ack_run = 0;
      ack_win = ack_exp;
      hold(1'b0, 40);
      ack_win = 1'b0;
      if (ack_exp) chk(ack_run == ACKC, "R5", "acknowledge width", ack_run, ACKC);
   endtask

   task automatic send_frame(input logic [23:0] a, input logic [3:0] f, input int sz,
                             input int sdelta, input int badord);
      logic [7:0] d[20];
      logic [7:0] s;
      ev_t e;
      int o;
      s = 8'h0F + 8'(sz);
      for (int i = 0; i < 20; i++) d[i] = 8'(i * 37 + sz * 11 + 5);
      for (int i = 0; i < sz; i++) s = s + d[i];
      s = s + 8'(sdelta);
      e = '0;
      if (badord >= 0)    e.kind = 3'd2;
      else if (sz > MAXL) e.kind = 3'd4;
      else                e.kind = 3'd1;
      e.cerr = (e.kind == 3'd1) && (8'(sdelta) != 8'd0);
      e.addr = a;
      e.fld  = f;
      e.size = 8'(sz);
      for (int i = 0; i < sz && i < MAXL; i++) e.data[i*8 +: 8] = d[i];
      exq.push_back(e);
      send_start();
      for (o = 0; o < 3; o++) begin
         send_byte(a[23 - 8*o -: 8], badord == o, (o == 2) && (badord != o));
         if (badord == o) begin hold(1'b0, 30); return; end
      end
      for (int i = 3; i >= 0; i--) send_bit(f[i]);
      send_byte(8'(sz), badord == 3, (badord != 3) && (sz <= MAXL));
      if (badord == 3 || sz > MAXL) begin hold(1'b0, 30); return; end
      for (int i = 0; i < sz; i++) begin
         send_byte(d[i], badord == 4 + i, badord != 4 + i);
         if (badord == 4 + i) begin hold(1'b0, 30); return; end
      end
      send_byte(s, badord == 4 + sz, badord != 4 + sz);
      hold(1'b0, 30);
   endtask

   initial begin
      tx = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(ack_drive == 1'b0, "R1", "ack_drive after reset", ack_drive, 0);
      chk({frame_valid, checksum_error, parity_error, timeout_error, length_error} == 5'b0,
          "R1", "status after reset",
          {frame_valid, checksum_error, parity_error, timeout_error, length_error}, 0);
      mon_on = 1'b1;
      hold(1'b0, 20);

      send_frame(24'h886800, 4'hF, 3, 0, -1);      // R3 R6 mixed bits
      send_frame(24'hA5015A, 4'h9, 0, 0, -1);      // R11 zero length
      send_frame(24'hFFFFFF, 4'h0, MAXL, 0, -1);   // R6 full buffer
      send_frame(24'h123456, 4'hF, 2, 1, -1);      // R7 bad checksum
      send_frame(24'h0F0F0F, 4'hF, 3, 0, 1);       // R4 parity fault, second byte
      send_frame(24'h30C003, 4'hF, 3, 0, 4);       // R4 parity fault, first payload byte
      send_frame(24'h00FF00, 4'hF, MAXL + 1, 0, -1); // R8 oversize length

      // R9 timeout after one address byte
      mon_e = '0;
      mon_e.kind = 3'd3;
      exq.push_back(mon_e);
      send_start();
      send_byte(8'h77, 1'b0, 1'b0);
      hold(1'b0, 100);

      // R2 restart in the middle of a frame
      send_start();
      send_byte(8'h11, 1'b0, 1'b0);
      send_byte(8'h22, 1'b0, 1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      send_frame(24'h5A5A5A, 4'hF, 1, 0, -1);      // R2 only this frame reports

      hold(1'b0, 100);
      chk(exq.size() == 0, "R2", "expected events left unmatched", exq.size(), 0);
      chk(ack_drive == 1'b0, "R5", "ack released at end", ack_drive, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule